// File: doc/BRIEF.md
# Position Word Serial Readout Port

This block is a read-only serial slave port with three wires. It gives a host access to a 16-bit word that holds status flags and a position value. The word at its input is live and may change on any system clock. When the host pulls chip-select low, the port copies that word into a shift register in one system clock cycle. From then on, later changes to the input cannot tear the word being read. The host then toggles a serial clock, and each rising edge moves the next frame bit onto the data line, most significant bit first.

The port drives a data output and an output-enable. Outside a read, the enable stays low, so the pad can be tri-stated and several ports can share one data line. Chip-select and serial clock are sampled into the system clock domain by two-flop synchronisers, and all decisions are made on edges of the synchronised samples. A read ends whenever chip-select rises, after the full word or part-way through it. The port also raises a one-cycle flag when the host gives a serial clock edge too soon after chip-select falls.

Top module: `pos_readout_port`

## Requirements
- R1: While reset is asserted, and after it is released with chip-select high, `sdo`, `sdo_oe` and `timing_err` are all 0.
- R2: Three system clocks after `cs_n` is sampled high, `sdo_oe` is 0, and it stays 0 for as long as `cs_n` stays high.
- R3: Three system clocks after `cs_n` is first sampled low, `sdo_oe` is 1 and `sdo` is 0. On that same detection cycle the word on `word_i` is captured whole.
- R4: Rising serial clock edge k (k = 1..16) after the capture puts frame bit 16-k on `sdo`, three system clocks after the edge is sampled. The frame layout is: bit 15 loss-of-signal, bit 14 overrange, bit 13 underrange, bit 12 sign, bits 11..0 magnitude.
- R5: Rising serial clock edges after the 16th, with chip-select still low, put 0 on `sdo`.
- R6: Changes on `word_i` after the capture have no effect on the bits shifted out in that read.
- R7: Raising `cs_n` part-way through a word ends the read: `sdo_oe` falls. The next falling chip-select captures a fresh word, and shifting starts again from bit 15.
- R8: Serial clock edges while `cs_n` is high leave `sdo_oe` at 0 and do not change the bit order of the next read.
- R9: Suppose a rising serial clock edge is sampled fewer than `SETUP_CYC` system clocks after the falling chip-select is sampled, while chip-select is still low. Then `timing_err` pulses high for one cycle, with the same latency as `sdo`. Edges sampled `SETUP_CYC` or more clocks after the fall never raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select from the host, active low, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| word_i | input | 16 | Live status-plus-position word |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Enable for the tri-state data pad |
| timing_err | output | 1 | One-cycle pulse on a serial clock edge that comes too early |

## Verification
The assertions check the following on every cycle:
- the output enable drops whenever synchronised chip-select is high;
- a capture always leaves the line enabled and low;
- the data bit holds still between serial clock edges;
- every edge past the sixteenth shifts a zero;
- `timing_err` appears only after a sampled edge, and never after the setup window has run out.

Some properties can only be shown by the bench's scenarios:
- the actual bit order of captured words;
- that an input word changed mid-read does not reach the line;
- that an aborted read is followed by a fresh capture from bit 15;
- that clocks given while deselected leave no trace.

// File: rtl/prp_pkg.sv
`timescale 1ns/1ps
package prp_pkg;
  localparam int FRAME_W   = 16;
  localparam int SETUP_DEF = 150;

  // decoded events from the synchronised host pins
  typedef struct packed {
    logic cs_fall;
    logic cs_rise;
    logic cs_low;
    logic sclk_rise;
  } prp_evt_t;
endpackage

// File: rtl/prp_sync_edge.sv
`timescale 1ns/1ps
module prp_sync_edge #(
  parameter int           N       = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] last_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta_q, stab_q, hist_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
        hist_q <= RST_VAL[g];
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
        hist_q <= stab_q;
      end
    end
    assign cur_o[g]  = stab_q;
    assign last_o[g] = hist_q;
  end
endmodule

// File: rtl/prp_shifter.sv
`timescale 1ns/1ps
module prp_shifter
  import prp_pkg::*;
#(
  parameter int W = FRAME_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  prp_evt_t     evt,
  input  logic [W-1:0] word_i,
  output logic         sdo,
  output logic         sdo_oe
);
  // one guard bit on top: the line is low until the first edge
  logic [W:0] sh_q, sh_d;
  logic       act_q, act_d;
  logic       sh_en;

  always_comb begin
    sh_d  = sh_q;
    act_d = act_q;
    if (evt.cs_fall) begin
      sh_d  = {1'b0, word_i};
      act_d = 1'b1;
    end else if (evt.cs_rise) begin
      sh_d  = '0;
      act_d = 1'b0;
    end else if (act_q && evt.sclk_rise) begin
      sh_d  = {sh_q[W-1:0], 1'b0};
    end
  end

  assign sh_en = evt.cs_fall | evt.cs_rise | (act_q & evt.sclk_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      act_q <= 1'b0;
    end else if (sh_en) begin
      sh_q  <= sh_d;
      act_q <= act_d;
    end
  end

  assign sdo    = sh_q[W];
  assign sdo_oe = act_q;
endmodule

// File: rtl/prp_setup_timer.sv
`timescale 1ns/1ps
module prp_setup_timer
  import prp_pkg::*;
#(
  parameter int SETUP_CYC = SETUP_DEF
) (
  input  logic     clk,
  input  logic     rst_n,
  input  prp_evt_t evt,
  output logic     timing_err
);
  localparam int             CW    = $clog2(SETUP_CYC + 1);
  localparam logic [CW-1:0]  LIMIT = CW'(SETUP_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          err_q, err_d;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (evt.cs_fall) begin
      cnt_en = 1'b1;
      cnt_d  = CW'(1);
    end else if (cnt_q < LIMIT) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CW'(1);
    end
    err_d = evt.sclk_rise & (evt.cs_fall | (evt.cs_low & (cnt_q < LIMIT)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LIMIT;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign timing_err = err_q;
endmodule

// File: rtl/pos_readout_port.sv
`timescale 1ns/1ps
module pos_readout_port
  import prp_pkg::*;
#(
  parameter int FRAME_BITS = FRAME_W,
  parameter int SETUP_CYC  = SETUP_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  sclk,
  input  logic [FRAME_BITS-1:0] word_i,
  output logic                  sdo,
  output logic                  sdo_oe,
  output logic                  timing_err
);
  localparam int PIN_N = 2;  // index 0: chip-select, index 1: serial clock

  logic [PIN_N-1:0] pin_cur, pin_last;
  prp_evt_t         evt;
  logic             cs_fall, cs_rise, cs_low, sclk_rise;

  prp_sync_edge #(.N(PIN_N), .RST_VAL(2'b01)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sclk, cs_n}),
    .cur_o   (pin_cur),
    .last_o  (pin_last)
  );

  assign cs_fall   =  pin_last[0] & ~pin_cur[0];
  assign cs_rise   = ~pin_last[0] &  pin_cur[0];
  assign cs_low    = ~pin_cur[0];
  assign sclk_rise = ~pin_last[1] &  pin_cur[1];
  assign evt       = '{cs_fall: cs_fall, cs_rise: cs_rise, cs_low: cs_low, sclk_rise: sclk_rise};

  prp_shifter #(.W(FRAME_BITS)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .word_i (word_i),
    .sdo    (sdo),
    .sdo_oe (sdo_oe)
  );

  prp_setup_timer #(.SETUP_CYC(SETUP_CYC)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt),
    .timing_err (timing_err)
  );
endmodule

// File: rtl/pos_readout_port_chk.sv
`timescale 1ns/1ps
module pos_readout_port_chk #(
  parameter int FRAME_BITS = 16,
  parameter int SETUP_CYC  = 150
) (
  input logic clk,
  input logic rst_n,
  input logic cs_fall,
  input logic cs_low,
  input logic sclk_rise,
  input logic sdo,
  input logic sdo_oe,
  input logic timing_err
);
  localparam int            BW   = $clog2(FRAME_BITS + 2);
  localparam logic [BW-1:0] BLIM = BW'(FRAME_BITS);
  localparam int            CW   = $clog2(SETUP_CYC + 1);
  localparam logic [CW-1:0] SLIM = CW'(SETUP_CYC);

  logic [BW-1:0] edges_q;
  logic [CW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges_q <= '0;
      since_q <= SLIM;
    end else begin
      if (cs_fall) edges_q <= '0;
      else if (cs_low && sclk_rise && edges_q <= BLIM) edges_q <= edges_q + BW'(1);
      if (cs_fall) since_q <= CW'(1);
      else if (since_q < SLIM) since_q <= since_q + CW'(1);
    end
  end

  p_oe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_low |=> !sdo_oe);

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (sdo_oe && !sdo));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && cs_low && !cs_fall && !sclk_rise) |=> $stable(sdo));

  p_zero_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_low && !cs_fall && sclk_rise && edges_q >= BLIM) |=> !sdo);

  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timing_err |-> $past(sclk_rise));

  p_err_late_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_low && !cs_fall && sclk_rise && since_q >= SLIM) |=> !timing_err);
endmodule

bind pos_readout_port pos_readout_port_chk #(
  .FRAME_BITS (FRAME_BITS),
  .SETUP_CYC  (SETUP_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_fall    (cs_fall),
  .cs_low     (cs_low),
  .sclk_rise  (sclk_rise),
  .sdo        (sdo),
  .sdo_oe     (sdo_oe),
  .timing_err (timing_err)
);

// File: tb/pos_readout_port_tb.sv
`timescale 1ns/1ps
module pos_readout_port_tb;
  localparam int SETUP = 150;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic [15:0] word_i = 16'h0000;
  logic        sdo, sdo_oe, timing_err;

  int total = 0;
  int bad = 0;
  int err_pulses = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  pos_readout_port #(.FRAME_BITS(16), .SETUP_CYC(SETUP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .word_i(word_i),
    .sdo(sdo), .sdo_oe(sdo_oe), .timing_err(timing_err)
  );

  // behavioural reference: pin samples pass through a three-sample queue
  int        cq[$];
  int        sq[$];
  logic [16:0] m_sh;
  bit        m_act, m_err;
  int        m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cq = '{1, 1, 1};
      sq = '{0, 0, 0};
      m_sh = '0; m_act = 0; m_err = 0; m_cnt = SETUP;
    end else begin
      bit fall, rise, srise, low;
      fall  = (cq[0] == 1) && (cq[1] == 0);
      rise  = (cq[0] == 0) && (cq[1] == 1);
      low   = (cq[1] == 0);
      srise = (sq[0] == 0) && (sq[1] == 1);
      m_err = srise && (fall || (low && m_cnt < SETUP));
      if (fall) m_cnt = 1; else if (m_cnt < SETUP) m_cnt++;
      if (fall) begin m_sh = {1'b0, word_i}; m_act = 1; end
      else if (rise) begin m_sh = '0; m_act = 0; end
      else if (m_act && srise) m_sh = m_sh << 1;
      void'(cq.pop_front()); cq.push_back(int'(cs_n));
      void'(sq.pop_front()); sq.push_back(int'(sclk));
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total += 3;
      if (sdo_oe !== m_act) begin
        bad++; $display("FAIL R2 oe: act=%0d exp=%0d t=%0t", sdo_oe, m_act, $time);
      end
      if (sdo !== m_sh[16]) begin
        bad++; $display("FAIL R4 sdo: act=%0d exp=%0d t=%0t", sdo, m_sh[16], $time);
      end
      if (timing_err !== m_err) begin
        bad++; $display("FAIL R9 err: act=%0d exp=%0d t=%0t", timing_err, m_err, $time);
      end
      if (timing_err === 1'b1) err_pulses++;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(output logic b);
    @(negedge clk) sclk = 1'b1;
    wait_n(4);
    b = sdo;
    sclk = 1'b0;
    wait_n(4);
  endtask

  task automatic select(logic [15:0] w);
    @(negedge clk) word_i = w;
    cs_n = 1'b0;
    wait_n(SETUP + 8);
  endtask

  task automatic deselect();
    @(negedge clk) cs_n = 1'b1;
    wait_n(6);
  endtask

  task automatic read_bits(int n, logic [15:0] exp, string req);
    for (int i = 0; i < n; i++) begin
      logic b, e;
      pulse(b);
      e = (i < 16) ? exp[15 - i] : 1'b0;
      check(b === e, (i < 16) ? req : "R5", int'(b), int'(e));
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic b;
    wait_n(3);
    check(sdo_oe === 1'b0 && sdo === 1'b0 && timing_err === 1'b0, "R1 in reset", int'(sdo_oe), 0);
    @(negedge clk) rst_n = 1'b1;
    wait_n(5);
    check(sdo_oe === 1'b0 && sdo === 1'b0 && timing_err === 1'b0, "R1 after reset", int'(sdo_oe), 0);

    // R3 capture, R4 bit order, R5 zero tail
    @(negedge clk) word_i = 16'hA5C3; cs_n = 1'b0;
    wait_n(4);
    check(sdo_oe === 1'b1, "R3 oe", int'(sdo_oe), 1);
    check(sdo === 1'b0, "R3 line low", int'(sdo), 0);
    wait_n(SETUP + 4);
    read_bits(19, 16'hA5C3, "R4");
    deselect();
    check(sdo_oe === 1'b0, "R2 released", int'(sdo_oe), 0);

    // R4 flag bits: loss-of-signal clear, over and under set
    select(16'h6FFF);
    read_bits(16, 16'h6FFF, "R4 flags");
    deselect();

    // R6 input changes after capture are ignored
    select(16'h8001);
    @(negedge clk) word_i = 16'h7FFE;
    read_bits(16, 16'h8001, "R6");
    deselect();

    // R7 abort after 5 bits, then fresh capture
    select(16'hF0F0);
    read_bits(5, 16'hF0F0, "R7 partial");
    deselect();
    check(sdo_oe === 1'b0, "R7 abort oe", int'(sdo_oe), 0);
    select(16'h1234);
    read_bits(16, 16'h1234, "R7 fresh");
    deselect();

    // R8 clocks while deselected
    for (int i = 0; i < 5; i++) begin
      pulse(b);
      check(sdo_oe === 1'b0, "R8 oe idle", int'(sdo_oe), 0);
    end
    select(16'hC00C);
    read_bits(16, 16'hC00C, "R8 order");
    deselect();

    // R9 early edge raises the flag, a timely read does not
    err_pulses = 0;
    @(negedge clk) word_i = 16'h5555; cs_n = 1'b0;
    wait_n(20);
    pulse(b);
    wait_n(4);
    check(err_pulses == 1, "R9 early", err_pulses, 1);
    deselect();
    err_pulses = 0;
    select(16'h0F0F);
    read_bits(16, 16'h0F0F, "R9 timely read");
    check(err_pulses == 0, "R9 timely", err_pulses, 0);
    deselect();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule